// File: doc/BRIEF.md
# Buffered Two-Requester Image Memory Controller

This block sits between two independent requesters, a general processing port (`gp_*`) and an image analyzer port (`ia_*`), and a word-addressed image memory of 16-bit words with 16-bit addresses. The two low address bits pick a word inside a four-word group. The upper fourteen bits name the group. A single four-word line buffer holds the most recently used group together with its group tag, a valid flag and a dirty flag.

A request whose group matches the buffered tag is served straight from the buffer and costs no memory cycle. On a mismatch, a dirty buffer is first written back to memory as four word writes in ascending word order. The new group is then fetched as four word reads in ascending order, and the request completes against the freshly filled buffer. A free-running timer asks for a refresh cycle at a fixed interval. The controller takes that refresh only at an idle point, never inside a write-back or fill.

A behavioural memory model with a fixed per-word latency stands in for the dynamic RAM. The model stores `2**MODEL_AW` words, and it aliases the address bits above that depth.

Top module: `dbuf_dram_ctrl`

## Requirements
- R1: While reset is held and after it is released, `gp_ack`, `ia_ack`, `buf_hit` and `rfsh_active` are 0 and the buffer is invalid. The first access after reset therefore misses with `buf_hit`=0 and performs no write-back: its latency equals the clean-miss latency of R4.
- R2: A read returns the value last written to the same 16-bit address through either port, or 0 if that address was never written. Bits [1:0] of the address select the word within its group.
- R3: A request whose address bits [15:2] equal the tag of a valid buffer is a hit. It completes with no memory cycle, and its ack is raised on the first clock edge after the controller samples the request (latency 1), with `buf_hit`=1 during the ack cycle.
- R4: A miss while the buffer is invalid or clean fetches the four words of the new group and completes with `buf_hit`=0. Its latency is 4*(MEM_LAT+2)+1 cycles.
- R5: A miss while the buffer is dirty first writes all four buffered words back in ascending word order, then fetches the new group. Its latency is 8*(MEM_LAT+2)+1 cycles, and the written-back data is returned by later reads of those addresses.
- R6: A write that hits updates the addressed word and marks the buffer dirty. A write that misses fills the group, then merges its data and marks the buffer dirty. A read miss leaves the buffer clean, so the next miss takes the R4 latency.
- R7: Each ack is a single-cycle pulse, and the two acks are never high in the same cycle. A requester holds its request until its ack and drops it during the ack cycle.
- R8: When both requesters ask in the same cycle, the one not served most recently goes first, and the other is served afterwards. After reset the general processing port counts as the one to go first.
- R9: A refresh is requested every RFSH_PERIOD cycles. A pending refresh is taken at an idle point, ahead of any waiting request, and never inside a write-back or fill. `rfsh_active` stays high for MEM_LAT+2 cycles per refresh, and successive refreshes start at most RFSH_PERIOD+8*(MEM_LAT+2)+6 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gp_req | input | 1 | General port request, held until acked |
| gp_we | input | 1 | General port direction, 1 = write |
| gp_addr | input | 16 | General port word address |
| gp_wdata | input | 16 | General port write data |
| gp_ack | output | 1 | General port completion pulse |
| gp_rdata | output | 16 | General port read data, valid with ack |
| ia_req | input | 1 | Analyzer port request, held until acked |
| ia_we | input | 1 | Analyzer port direction, 1 = write |
| ia_addr | input | 16 | Analyzer port word address |
| ia_wdata | input | 16 | Analyzer port write data |
| ia_ack | output | 1 | Analyzer port completion pulse |
| ia_rdata | output | 16 | Analyzer port read data, valid with ack |
| buf_hit | output | 1 | High with the ack when the access was served from the buffer |
| rfsh_active | output | 1 | High while a refresh cycle occupies the memory |

## Verification
The delicate coincidence is a refresh coming due in the very cycle that both requesters raise their requests, so that refresh and two-way arbitration compete at one idle point. The bench first locks onto the refresh rhythm by watching two `rfsh_active` rises while idle. It then raises both requests on the cycle just before the next refresh is taken. It expects `rfsh_active` to be seen first, followed by the two acks in round-robin order, each with the read data and hit flag that its own model predicts for that order.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 16;
    localparam int OFS_W      = 2;
    localparam int LINE_WORDS = 1 << OFS_W;
    localparam int TAG_W      = ADDR_W - OFS_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RFSH,
        ST_WB,
        ST_FILL,
        ST_ACK
    } ctl_state_e;

    typedef enum logic [1:0] {
        RAM_RD,
        RAM_WR,
        RAM_RFSH
    } ram_op_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } acc_req_t;

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFS_W];
    endfunction

    function automatic logic [OFS_W-1:0] ofs_of(input logic [ADDR_W-1:0] a);
        return a[OFS_W-1:0];
    endfunction

endpackage

// File: rtl/dbuf_rr_arb.sv
module dbuf_rr_arb (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req,
    input  logic       served,
    input  logic       served_idx,
    output logic       gnt_any,
    output logic       gnt_idx
);
    logic last_q;

    always_ff @(posedge clk) begin
        if (rst)         last_q <= 1'b1;
        else if (served) last_q <= served_idx;
    end

    assign gnt_any = |req;
    assign gnt_idx = (req == 2'b11) ? ~last_q : req[1];

    AST_RR_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        (served && req == 2'b11) |=> (gnt_idx != $past(served_idx))); // R8

endmodule

// File: rtl/dbuf_rfsh_timer.sv
module dbuf_rfsh_timer #(
    parameter int PERIOD = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    output logic pend
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            pend  <= 1'b0;
        end else begin
            if (cnt_q == CNT_W'(PERIOD - 1)) begin
                cnt_q <= '0;
                pend  <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (take) pend <= 1'b0;
            end
        end
    end

    AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
        (pend && !take) |=> pend); // R9

endmodule

// File: rtl/dbuf_ram_model.sv
module dbuf_ram_model
    import dbuf_pkg::*;
#(
    parameter int LAT      = 3,
    parameter int MODEL_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  ram_op_e           op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << MODEL_AW;
    localparam int CW    = $clog2(LAT + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              busy_q;
    logic [CW-1:0]     cnt_q;
    logic              unused_hi;

    assign unused_hi = ^addr[ADDR_W-1:MODEL_AW];

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            done   <= 1'b0;
            rdata  <= '0;
        end else begin
            done <= 1'b0;
            if (busy_q) begin
                if (cnt_q == CW'(LAT - 1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                    if (op == RAM_WR)      mem[addr[MODEL_AW-1:0]] <= wdata;
                    else if (op == RAM_RD) rdata <= mem[addr[MODEL_AW-1:0]];
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (req && !done) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5

endmodule

// File: rtl/dbuf_dram_ctrl.sv
module dbuf_dram_ctrl
    import dbuf_pkg::*;
#(
    parameter int MEM_LAT     = 3,
    parameter int RFSH_PERIOD = 200,
    parameter int MODEL_AW    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gp_req,
    input  logic              gp_we,
    input  logic [ADDR_W-1:0] gp_addr,
    input  logic [DATA_W-1:0] gp_wdata,
    output logic              gp_ack,
    output logic [DATA_W-1:0] gp_rdata,
    input  logic              ia_req,
    input  logic              ia_we,
    input  logic [ADDR_W-1:0] ia_addr,
    input  logic [DATA_W-1:0] ia_wdata,
    output logic              ia_ack,
    output logic [DATA_W-1:0] ia_rdata,
    output logic              buf_hit,
    output logic              rfsh_active
);
    localparam logic [OFS_W-1:0] LAST = OFS_W'(LINE_WORDS - 1);

    ctl_state_e        state;
    acc_req_t          req_in [2];
    acc_req_t          cur;
    logic              port_q;
    logic [OFS_W-1:0]  idx;
    logic [DATA_W-1:0] line_q [LINE_WORDS];
    logic [TAG_W-1:0]  tag_q;
    logic              valid_q, dirty_q, hit_q;
    logic [1:0]        ack_q;
    logic [DATA_W-1:0] rdata_q [2];

    logic              gnt_any, gnt_idx, hit_now, rfsh_pend, rfsh_take;
    logic              ram_req, ram_done;
    ram_op_e           ram_op;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_rdata;
    acc_req_t          sel;

    assign req_in[0] = '{we: gp_we, addr: gp_addr, wdata: gp_wdata};
    assign req_in[1] = '{we: ia_we, addr: ia_addr, wdata: ia_wdata};
    assign sel       = req_in[gnt_idx];
    assign hit_now   = valid_q && (tag_q == tag_of(sel.addr));

    dbuf_rr_arb u_arb (
        .clk(clk), .rst(rst), .req({ia_req, gp_req}),
        .served(state == ST_ACK), .served_idx(port_q),
        .gnt_any(gnt_any), .gnt_idx(gnt_idx)
    );

    dbuf_rfsh_timer #(.PERIOD(RFSH_PERIOD)) u_rfsh (
        .clk(clk), .rst(rst), .take(rfsh_take), .pend(rfsh_pend)
    );

    assign ram_req   = (state == ST_RFSH) || (state == ST_WB) || (state == ST_FILL);
    assign rfsh_take = (state == ST_RFSH) && ram_done;

    always_comb begin
        ram_op   = RAM_RFSH;
        ram_addr = {tag_of(cur.addr), idx};
        if (state == ST_WB) begin
            ram_op   = RAM_WR;
            ram_addr = {tag_q, idx};
        end else if (state == ST_FILL) begin
            ram_op   = RAM_RD;
        end
    end

    dbuf_ram_model #(.LAT(MEM_LAT), .MODEL_AW(MODEL_AW)) u_ram (
        .clk(clk), .rst(rst), .req(ram_req), .op(ram_op), .addr(ram_addr),
        .wdata(line_q[idx]), .done(ram_done), .rdata(ram_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur        <= '0;
            port_q     <= 1'b0;
            idx        <= '0;
            tag_q      <= '0;
            valid_q    <= 1'b0;
            dirty_q    <= 1'b0;
            hit_q      <= 1'b0;
            ack_q      <= '0;
            rdata_q[0] <= '0;
            rdata_q[1] <= '0;
            for (int i = 0; i < LINE_WORDS; i++) line_q[i] <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (rfsh_pend) begin
                        state <= ST_RFSH;
                    end else if (gnt_any) begin
                        cur    <= sel;
                        port_q <= gnt_idx;
                        idx    <= '0;
                        if (hit_now) begin
                            hit_q          <= 1'b1;
                            ack_q[gnt_idx] <= 1'b1;
                            state          <= ST_ACK;
                            if (sel.we) begin
                                line_q[ofs_of(sel.addr)] <= sel.wdata;
                                dirty_q                  <= 1'b1;
                            end else begin
                                rdata_q[gnt_idx] <= line_q[ofs_of(sel.addr)];
                            end
                        end else begin
                            state <= (valid_q && dirty_q) ? ST_WB : ST_FILL;
                        end
                    end
                end
                ST_RFSH: if (ram_done) state <= ST_IDLE;
                ST_WB: if (ram_done) begin
                    idx <= idx + 1'b1;
                    if (idx == LAST) state <= ST_FILL;
                end
                ST_FILL: if (ram_done) begin
                    line_q[idx] <= ram_rdata;
                    idx         <= idx + 1'b1;
                    if (idx == LAST) begin
                        tag_q         <= tag_of(cur.addr);
                        valid_q       <= 1'b1;
                        dirty_q       <= cur.we;
                        hit_q         <= 1'b0;
                        ack_q[port_q] <= 1'b1;
                        state         <= ST_ACK;
                        if (cur.we)
                            line_q[ofs_of(cur.addr)] <= cur.wdata;
                        else
                            rdata_q[port_q] <= (ofs_of(cur.addr) == LAST) ?
                                               ram_rdata : line_q[ofs_of(cur.addr)];
                    end
                end
                ST_ACK: begin
                    ack_q <= '0;
                    hit_q <= 1'b0;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign gp_ack      = ack_q[0];
    assign ia_ack      = ack_q[1];
    assign gp_rdata    = rdata_q[0];
    assign ia_rdata    = rdata_q[1];
    assign buf_hit     = hit_q;
    assign rfsh_active = (state == ST_RFSH);

    AST_ONE_ACK: assert property (@(posedge clk) disable iff (rst)
        !(gp_ack && ia_ack)); // R7
    AST_GP_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        gp_ack |=> !gp_ack); // R7
    AST_IA_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        ia_ack |=> !ia_ack); // R7
    AST_HIT_NO_RAM: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !rfsh_pend && gnt_any && hit_now) |=> !ram_req); // R3
    AST_RFSH_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RFSH && $past(state) != ST_RFSH) |-> $past(state) == ST_IDLE); // R9
    AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FILL && $past(state) == ST_WB) |-> $past(idx) == LAST); // R5
    AST_WORD_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (ram_done && (state == ST_WB || state == ST_FILL)) |=> idx == $past(idx) + 1'b1); // R5

endmodule

// File: tb/dbuf_dram_ctrl_tb.sv
module dbuf_dram_ctrl_tb;

    localparam int L    = 3;
    localparam int P    = 200;
    localparam int SLOT = L + 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        gp_req, gp_we, ia_req, ia_we;
    logic [15:0] gp_addr, gp_wdata, ia_addr, ia_wdata;
    logic        gp_ack, ia_ack, buf_hit, rfsh_active;
    logic [15:0] gp_rdata, ia_rdata;

    always #4 clk = ~clk;

    dbuf_dram_ctrl #(.MEM_LAT(L), .RFSH_PERIOD(P), .MODEL_AW(10)) u_dut (
        .clk(clk), .rst(rst),
        .gp_req(gp_req), .gp_we(gp_we), .gp_addr(gp_addr), .gp_wdata(gp_wdata),
        .gp_ack(gp_ack), .gp_rdata(gp_rdata),
        .ia_req(ia_req), .ia_we(ia_we), .ia_addr(ia_addr), .ia_wdata(ia_wdata),
        .ia_ack(ia_ack), .ia_rdata(ia_rdata),
        .buf_hit(buf_hit), .rfsh_active(rfsh_active)
    );

    int          errors = 0;
    int          checks = 0;
    logic [15:0] mdl [int];
    bit          bvalid = 0;
    bit          bdirty = 0;
    logic [13:0] btag = '0;
    bit          last_port = 1'b1;
    int          max_gap = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic int exp_lat(input logic [15:0] a);
        if (bvalid && btag == a[15:2]) return 1;
        if (bvalid && bdirty) return 8 * SLOT + 1;
        return 4 * SLOT + 1;
    endfunction

    function automatic string lat_req(input logic [15:0] a);
        if (!bvalid) return "R1";
        if (btag == a[15:2]) return "R3";
        if (bdirty) return "R5";
        return "R4";
    endfunction

    function automatic void mdl_apply(input bit we, input logic [15:0] a, input logic [15:0] wd,
                                      output logic [15:0] rd, output bit hit);
        hit = bvalid && (btag == a[15:2]);
        rd  = mdl.exists(int'(a)) ? mdl[int'(a)] : 16'h0;
        if (we) mdl[int'(a)] = wd;
        bdirty = hit ? (bdirty | we) : we;
        btag   = a[15:2];
        bvalid = 1'b1;
    endfunction

    task automatic drive(input bit p, input bit r, input bit we, input logic [15:0] a,
                         input logic [15:0] wd);
        if (p == 1'b0) begin gp_req = r; gp_we = we; gp_addr = a; gp_wdata = wd; end
        else           begin ia_req = r; ia_we = we; ia_addr = a; ia_wdata = wd; end
    endtask

    function automatic bit ack_of(input bit p);
        return p ? ia_ack : gp_ack;
    endfunction

    function automatic logic [15:0] rd_of(input bit p);
        return p ? ia_rdata : gp_rdata;
    endfunction

    task automatic single(input bit p, input bit we, input logic [15:0] a, input logic [15:0] wd,
                          input string ov);
        int          lat_exp;
        string       lrq;
        logic [15:0] erd;
        bit          ehit;
        int          n;
        bit          rf;
        lat_exp = exp_lat(a);
        lrq     = (ov != "") ? ov : lat_req(a);
        mdl_apply(we, a, wd, erd, ehit);
        last_port = p;
        n = 0;
        @(negedge clk);
        drive(p, 1'b1, we, a, wd);
        rf = rfsh_active;
        do begin
            @(negedge clk);
            n++;
            if (rfsh_active) rf = 1'b1;
        end while (!ack_of(p) && n < 2000);
        drive(p, 1'b0, we, a, wd);
        chk(ack_of(p), "R7", int'(ack_of(p)), 1);
        chk(!ack_of(!p), "R7", int'(ack_of(!p)), 0);
        chk(buf_hit == ehit, "R3", int'(buf_hit), int'(ehit));
        if (!we) chk(rd_of(p) == erd, "R2", int'(rd_of(p)), int'(erd));
        if (!rf) chk(n == lat_exp, lrq, n, lat_exp);
        @(negedge clk);
        chk(!ack_of(p), "R7", int'(ack_of(p)), 0);
    endtask

    task automatic dual(input bit we0, input logic [15:0] a0, input logic [15:0] d0,
                        input bit we1, input logic [15:0] a1, input logic [15:0] d1,
                        input bit expect_rf);
        bit          first;
        logic [15:0] erd [2];
        bit          ehit [2];
        bit          seen [2];
        int          order;
        int          n;
        first = ~last_port;
        if (first == 1'b0) begin
            mdl_apply(we0, a0, d0, erd[0], ehit[0]);
            mdl_apply(we1, a1, d1, erd[1], ehit[1]);
        end else begin
            mdl_apply(we1, a1, d1, erd[1], ehit[1]);
            mdl_apply(we0, a0, d0, erd[0], ehit[0]);
        end
        last_port = ~first;
        seen[0] = 0; seen[1] = 0; order = -1; n = 0;
        @(negedge clk);
        drive(1'b0, 1'b1, we0, a0, d0);
        drive(1'b1, 1'b1, we1, a1, d1);
        do begin
            @(negedge clk);
            n++;
            if (n == 1 && expect_rf) chk(rfsh_active, "R9", int'(rfsh_active), 1);
            if (gp_ack && ia_ack) chk(0, "R7", 1, 0);
            for (int p = 0; p < 2; p++) begin
                if (ack_of(p[0]) && !seen[p]) begin
                    seen[p] = 1'b1;
                    if (order < 0) order = p;
                    chk(buf_hit == ehit[p], "R3", int'(buf_hit), int'(ehit[p]));
                    if ((p == 0 && !we0) || (p == 1 && !we1))
                        chk(rd_of(p[0]) == erd[p], "R2", int'(rd_of(p[0])), int'(erd[p]));
                    drive(p[0], 1'b0, 1'b0, 16'h0, 16'h0);
                end
            end
        end while (!(seen[0] && seen[1]) && n < 4000);
        chk(order == int'(first), "R8", order, int'(first));
    endtask

    task automatic wait_rise();
        bit prev;
        prev = rfsh_active;
        forever begin
            @(negedge clk);
            if (rfsh_active && !prev) break;
            prev = rfsh_active;
        end
    endtask

    // refresh rhythm and width monitor
    initial begin
        int  gap;
        int  width;
        bit  prev;
        bit  have;
        gap = 0; width = 0; prev = 0; have = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                gap = 0; width = 0; prev = 0; have = 0;
            end else begin
                gap++;
                if (rfsh_active) width++;
                if (rfsh_active && !prev) begin
                    if (have && gap > max_gap) max_gap = gap;
                    have = 1;
                    gap  = 0;
                end
                if (!rfsh_active && prev) begin
                    chk(width == SLOT, "R9", width, SLOT);
                    width = 0;
                end
                prev = rfsh_active;
            end
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R7: watchdog expired, got 0 expected 1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] a;
        void'($urandom(32'd20240611));
        rst = 1'b1;
        gp_req = 0; gp_we = 0; gp_addr = '0; gp_wdata = '0;
        ia_req = 0; ia_we = 0; ia_addr = '0; ia_wdata = '0;
        repeat (3) @(negedge clk);
        chk(!gp_ack && !ia_ack, "R1", int'({gp_ack, ia_ack}), 0);
        chk(!buf_hit && !rfsh_active, "R1", int'({buf_hit, rfsh_active}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!gp_ack && !ia_ack && !buf_hit, "R1", int'({gp_ack, ia_ack, buf_hit}), 0);

        // directed: first miss, hits, write hit, dirty eviction, read back
        single(1'b0, 1'b0, 16'h0010, 16'h0, "");
        single(1'b0, 1'b0, 16'h0013, 16'h0, "");
        single(1'b1, 1'b1, 16'h0011, 16'hBEEF, "R6");
        single(1'b0, 1'b0, 16'h0011, 16'h0, "");
        single(1'b0, 1'b0, 16'h0020, 16'h0, "R6");
        single(1'b1, 1'b0, 16'h0011, 16'h0, "R4");
        single(1'b0, 1'b1, 16'h0043, 16'h1234, "R6");
        single(1'b1, 1'b0, 16'h0010, 16'h0, "R5");
        single(1'b0, 1'b0, 16'h0043, 16'h0, "R2");

        // directed: simultaneous requests
        dual(1'b0, 16'h0012, 16'h0, 1'b1, 16'h0030, 16'h5A5A, 1'b0);
        dual(1'b1, 16'h0031, 16'h7777, 1'b0, 16'h0030, 16'h0, 1'b0);

        // directed: refresh coming due together with both requests
        repeat (4) @(negedge clk);
        wait_rise();
        wait_rise();
        repeat (P - 2) @(negedge clk);
        dual(1'b0, 16'h0031, 16'h0, 1'b0, 16'h0040, 16'h0, 1'b1);

        // constrained random traffic over a few groups
        for (int i = 0; i < 300; i++) begin
            a = 16'(($urandom % 6) * 4 + ($urandom % 4));
            if (($urandom % 5) == 0)
                dual(1'($urandom), a, 16'($urandom), 1'($urandom),
                     16'(($urandom % 6) * 4 + ($urandom % 4)), 16'($urandom), 1'b0);
            else
                single(1'($urandom), 1'($urandom), a, 16'($urandom), "");
        end

        repeat (20) @(negedge clk);
        chk(max_gap > 0 && max_gap <= P + 8 * SLOT + 6, "R9", max_gap, P + 8 * SLOT + 6);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule